// File: doc/BRIEF.md
# Receive DMA Countdown and End-Padding Unit

This unit sits between a receive data FIFO and the host read port. Each host read strobe moves one DWORD. A 12-bit transfer count, loaded through a single configuration register, drops by one for every DWORD delivered. The read that takes the count from one to zero raises a DMA-done interrupt. Software may reload the count at any time, and counting then continues from the new value.

The same register holds an end-alignment selector. When the FIFO marks a DWORD as the last real word of a packet, the unit appends zero-valued pad DWORDs. Padding stops when the number of DWORDs in the buffer reaches a multiple of the chosen alignment. The alignment is captured at the first read of each packet, so a register change in the middle of a packet does not disturb that packet. Such a change is instead reported on an error flag.

Top module: `rx_dma_align`

## Requirements
- R1: After a synchronous reset, cfg_rdata is zero (count 0, alignment 00), and dma_irq and align_err are low.
- R2: A cfg_we write loads the count from cfg_wdata[27:16] and the alignment from cfg_wdata[31:30]. On cfg_rdata, bits 29:28 and 15:0 always read as zero, and bits 27:16 show the live count.
- R3: Each cycle with rd_en high and no write lowers a nonzero count by one. A count of zero stays at zero.
- R4: dma_irq rises in the cycle after a read takes the count from 1 to 0, and stays high until the next cfg_we write clears it. Writing a count of zero never raises dma_irq.
- R5: A write issued before the count reaches zero replaces it, and later reads count down from the new value. A write in the same cycle as a read takes priority, and that read does not decrement.
- R6: The alignment codes are 00 for no padding, 01 for a multiple of 4 DWORDs, 10 for a multiple of 8 DWORDs, and 11 for no padding. After the DWORD read with fifo_eop high, pad reads follow until the packet's DWORD total reaches that multiple.
- R7: During a pad read, rd_pad is 1 and rd_data is 0x00000000. During a real read, rd_pad is 0 and rd_data equals fifo_rdata. Pad reads decrement the count like real reads.
- R8: The alignment field is sampled on the first read of each packet. Changes made later do not affect that packet's padding.
- R9: A write that changes the alignment field, made after a packet's first read and through the cycle of its last DWORD, sets align_err in the next cycle. A write that keeps the same field does not set it. align_err clears after the first read of the next packet.
- R10: rd_last is high only during the final DWORD read of a buffer. That is the last pad read, or the fifo_eop read when no pad is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Configuration readback with live count |
| rd_en | input | 1 | Host reads one DWORD this cycle |
| fifo_rdata | input | 32 | DWORD at the FIFO head |
| fifo_eop | input | 1 | FIFO head is the last real DWORD of the packet |
| rd_data | output | 32 | DWORD returned to the host (real or pad) |
| rd_pad | output | 1 | Current read is a pad DWORD |
| rd_last | output | 1 | Current read ends the buffer |
| dma_irq | output | 1 | DMA-done interrupt |
| align_err | output | 1 | Alignment changed during a packet |

## Verification
A wrong count shows up on cfg_rdata in the cycle after the faulty read, and it moves dma_irq early or late by the same number of reads. A wrong latched alignment or a wrong position counter shows only at the end of a packet, as the wrong number of pad reads or a misplaced rd_last, so each packet length is chosen to leave a distinct pad total. The error flag is checked on the cycle after the mid-packet write, and again after the next packet's first read.

// File: rtl/rxda_pkg.sv
package rxda_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 12;
    localparam int CNT_LO   = 16;
    localparam int ALIGN_LO = 30;
    localparam int POS_W    = 3;

    typedef enum logic [1:0] {
        AL_NONE = 2'b00,
        AL_4DW  = 2'b01,
        AL_8DW  = 2'b10,
        AL_RSVD = 2'b11
    } align_e;

    typedef enum logic [1:0] {
        PS_IDLE = 2'b00,
        PS_DATA = 2'b01,
        PS_PAD  = 2'b10
    } pad_state_e;

    typedef struct packed {
        align_e           align;
        logic [CNT_W-1:0] count;
    } cfg_t;

    function automatic logic [POS_W-1:0] align_mask(align_e a);
        case (a)
            AL_4DW:  return 3'd3;
            AL_8DW:  return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [POS_W-1:0] pad_needed(align_e a, logic [POS_W-1:0] n);
        return (3'd0 - n) & align_mask(a);
    endfunction
endpackage

// File: rtl/rxda_cfg.sv
module rxda_cfg
    import rxda_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              pkt_start,
    output align_e            align_f,
    output logic              err
);
    align_e new_align;
    assign new_align = align_e'(wdata[ALIGN_LO +: 2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            align_f <= AL_NONE;
            err     <= 1'b0;
        end else begin
            if (we) align_f <= new_align;
            if (we && busy && (new_align != align_f))
                err <= 1'b1;
            else if (pkt_start)
                err <= 1'b0;
        end
    end
endmodule

// File: rtl/rxda_dma_cnt.sv
module rxda_dma_cnt
    import rxda_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    logic at_one;
    assign at_one = (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
        end else if (load) begin
            cnt <= load_val;
            irq <= 1'b0;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
            if (at_one) irq <= 1'b1;
        end
    end
endmodule

// File: rtl/rxda_pad_seq.sv
module rxda_pad_seq
    import rxda_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rd,
    input  logic   eop,
    input  align_e align_f,
    output logic   busy,
    output logic   pad,
    output logic   last
);
    pad_state_e       state;
    align_e           align_q;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] pad_left;

    align_e           cur_align;
    logic [POS_W-1:0] next_pos;
    logic [POS_W-1:0] pad_cnt;

    always_comb begin
        cur_align = (state == PS_IDLE) ? align_f : align_q;
        next_pos  = (state == PS_IDLE) ? POS_W'(1) : pos + POS_W'(1);
        pad_cnt   = pad_needed(cur_align, next_pos);
    end

    assign busy = (state != PS_IDLE);
    assign pad  = (state == PS_PAD);
    assign last = rd && ((pad && (pad_left == POS_W'(1))) ||
                         (!pad && eop && (pad_cnt == '0)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_IDLE;
            align_q  <= AL_NONE;
            pos      <= '0;
            pad_left <= '0;
        end else if (rd) begin
            case (state)
                PS_PAD: begin
                    pad_left <= pad_left - POS_W'(1);
                    if (pad_left == POS_W'(1)) state <= PS_IDLE;
                end
                default: begin
                    if (state == PS_IDLE) align_q <= align_f;
                    pos <= next_pos;
                    if (!eop) begin
                        state <= PS_DATA;
                    end else if (pad_cnt == '0) begin
                        state <= PS_IDLE;
                    end else begin
                        state    <= PS_PAD;
                        pad_left <= pad_cnt;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/rx_dma_align.sv
module rx_dma_align
    import rxda_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  logic              fifo_eop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_pad,
    output logic              rd_last,
    output logic              dma_irq,
    output logic              align_err
);
    cfg_t   cur;
    align_e align_f;
    logic   busy;

    rxda_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .busy      (busy),
        .pkt_start (rd_en && !busy),
        .align_f   (align_f),
        .err       (align_err)
    );

    rxda_dma_cnt u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_we),
        .load_val (cfg_wdata[CNT_LO +: CNT_W]),
        .dec      (rd_en),
        .cnt      (cur.count),
        .irq      (dma_irq)
    );

    rxda_pad_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .rd      (rd_en),
        .eop     (fifo_eop),
        .align_f (align_f),
        .busy    (busy),
        .pad     (rd_pad),
        .last    (rd_last)
    );

    assign cur.align = align_f;

    always_comb begin
        cfg_rdata = '0;
        cfg_rdata[ALIGN_LO +: 2]   = cur.align;
        cfg_rdata[CNT_LO +: CNT_W] = cur.count;
    end

    assign rd_data = rd_pad ? '0 : fifo_rdata;
endmodule

// File: rtl/rx_dma_align_chk.sv
module rx_dma_align_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic        rd_pad,
    input logic        rd_last,
    input logic        dma_irq,
    input logic        align_err
);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[29:28] == 2'b00) && (cfg_rdata[15:0] == 16'h0));

    assert_cnt_dec_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !cfg_we && cfg_rdata[27:16] != 12'h0)
        |=> cfg_rdata[27:16] == $past(cfg_rdata[27:16]) - 12'h1);

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_irq) |-> $past(rd_en && !cfg_we && cfg_rdata[27:16] == 12'h1));

    assert_write_wins_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata[27:16] == $past(cfg_wdata[27:16]));

    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (rst)
        rd_pad |-> rd_data == 32'h0);

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(align_err) |-> $past(cfg_we));

    assert_last_on_read_R10: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_en);
endmodule

bind rx_dma_align rx_dma_align_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_pad    (rd_pad),
    .rd_last   (rd_last),
    .dma_irq   (dma_irq),
    .align_err (align_err)
);

// File: tb/rx_dma_align_tb_top.sv
`timescale 1ns/1ps
module rx_dma_align_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rd_en = 1'b0;
    logic [31:0] fifo_rdata = '0;
    logic        fifo_eop = 1'b0;
    logic [31:0] rd_data;
    logic        rd_pad, rd_last, dma_irq, align_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rx_dma_align dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rd_en(rd_en), .fifo_rdata(fifo_rdata),
        .fifo_eop(fifo_eop), .rd_data(rd_data), .rd_pad(rd_pad),
        .rd_last(rd_last), .dma_irq(dma_irq), .align_err(align_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] d, input bit eop, input bit exp_pad,
                      input bit exp_last, input string req);
        @(negedge clk);
        rd_en = 1'b1; fifo_rdata = d; fifo_eop = eop;
        #1;
        chk_eq({req, " rd_pad"}, {31'b0, rd_pad}, {31'b0, exp_pad});
        chk_eq({req, " rd_data"}, rd_data, exp_pad ? 32'h0 : d);
        chk_eq({req, " rd_last"}, {31'b0, rd_last}, {31'b0, exp_last});
        @(posedge clk); #1;
        rd_en = 1'b0; fifo_eop = 1'b0;
    endtask

    function automatic logic [11:0] cnt_now();
        return cfg_rdata[27:16];
    endfunction

    task automatic t_reset();
        chk_eq("R1 cfg_rdata", cfg_rdata, 32'h0);
        chk_eq("R1 irq", {31'b0, dma_irq}, 32'h0);
        chk_eq("R1 err", {31'b0, align_err}, 32'h0);
    endtask

    task automatic t_write_fields();
        wr(32'h5ABC_FFFF);
        chk_eq("R2 readback", cfg_rdata, 32'h4ABC_0000);
        chk_eq("R2 irq low", {31'b0, dma_irq}, 32'h0);
    endtask

    task automatic t_count_irq();
        wr(32'h0003_0000);
        rd(32'h1111_0001, 0, 0, 0, "R3 p1");
        chk_eq("R3 dec", {20'b0, cnt_now()}, 32'd2);
        rd(32'h1111_0002, 0, 0, 0, "R3 p2");
        chk_eq("R4 no irq yet", {31'b0, dma_irq}, 32'h0);
        rd(32'h1111_0003, 1, 0, 1, "R10 eop no pad");
        chk_eq("R4 cnt zero", {20'b0, cnt_now()}, 32'd0);
        chk_eq("R4 irq set", {31'b0, dma_irq}, 32'h1);
        rd(32'h2222_0000, 1, 0, 1, "R3 at zero");
        chk_eq("R3 stays zero", {20'b0, cnt_now()}, 32'd0);
        chk_eq("R4 irq held", {31'b0, dma_irq}, 32'h1);
        wr(32'h0000_0000);
        chk_eq("R4 write clears", {31'b0, dma_irq}, 32'h0);
        repeat (3) @(posedge clk); #1;
        chk_eq("R4 zero write no irq", {31'b0, dma_irq}, 32'h0);
    endtask

    task automatic t_overwrite();
        wr(32'h0005_0000);
        rd(32'hA, 1, 0, 1, "R5 a");
        rd(32'hB, 1, 0, 1, "R5 b");
        chk_eq("R5 at 3", {20'b0, cnt_now()}, 32'd3);
        wr(32'h000A_0000);
        chk_eq("R5 reload", {20'b0, cnt_now()}, 32'd10);
        rd(32'hC, 1, 0, 1, "R5 c");
        chk_eq("R5 from new", {20'b0, cnt_now()}, 32'd9);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 32'h0002_0000;
        rd_en = 1'b1; fifo_rdata = 32'hD; fifo_eop = 1'b1;
        @(posedge clk); #1;
        cfg_we = 1'b0; rd_en = 1'b0; fifo_eop = 1'b0;
        chk_eq("R5 write wins", {20'b0, cnt_now()}, 32'd2);
        rd(32'hE, 1, 0, 1, "R5 e");
        rd(32'hF, 1, 0, 1, "R5 f");
        chk_eq("R4 irq after reload", {31'b0, dma_irq}, 32'h1);
    endtask

    task automatic t_align16();
        wr(32'h4000_0000);
        for (int i = 1; i <= 5; i++)
            rd(32'h3000_0000 + i, i == 5, 0, 0, "R6 a16 data");
        for (int i = 1; i <= 3; i++)
            rd(32'hDEAD_BEEF, 0, 1, i == 3, "R7 a16 pad");
        rd(32'h3333_0001, 0, 0, 0, "R6 a16 exact");
        rd(32'h3333_0002, 0, 0, 0, "R6 a16 exact");
        rd(32'h3333_0003, 0, 0, 0, "R6 a16 exact");
        rd(32'h3333_0004, 1, 0, 1, "R10 a16 exact last");
    endtask

    task automatic t_align32();
        wr(32'h8014_0000);
        for (int i = 1; i <= 3; i++)
            rd(32'h4000_0000 + i, i == 3, 0, 0, "R6 a32 data");
        for (int i = 1; i <= 5; i++)
            rd(32'hFFFF_FFFF, 0, 1, i == 5, "R6 a32 pad");
        chk_eq("R7 pads count", {20'b0, cnt_now()}, 32'd12);
        chk_eq("R7 irq low", {31'b0, dma_irq}, 32'h0);
    endtask

    task automatic t_align_rsvd();
        wr(32'hC000_0000);
        rd(32'h5, 0, 0, 0, "R6 rsvd");
        rd(32'h6, 0, 0, 0, "R6 rsvd");
        rd(32'h7, 1, 0, 1, "R6 rsvd no pad");
    endtask

    task automatic t_lock();
        wr(32'h8000_0000);
        rd(32'h7000_0001, 0, 0, 0, "R8 first");
        wr(32'h4000_0000);
        chk_eq("R9 err set", {31'b0, align_err}, 32'h1);
        rd(32'h7000_0002, 1, 0, 0, "R8 eop");
        for (int i = 1; i <= 6; i++)
            rd(32'h1234_5678, 0, 1, i == 6, "R8 latched pad");
        chk_eq("R9 err held", {31'b0, align_err}, 32'h1);
        rd(32'h7100_0001, 1, 0, 0, "R8 new align");
        chk_eq("R9 err cleared", {31'b0, align_err}, 32'h0);
        wr(32'h4000_0000);
        chk_eq("R9 same value", {31'b0, align_err}, 32'h0);
        for (int i = 1; i <= 3; i++)
            rd(32'h0, 0, 1, i == 3, "R8 pad new");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_write_fields();
        t_count_irq();
        t_overwrite();
        t_align16();
        t_align32();
        t_align_rsvd();
        t_lock();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule